// File: doc/BRIEF.md
# CAN Fault Confinement Controller

This block keeps track of how healthy a CAN node is, based on how many errors it has seen. It holds a transmit error counter and a receive error counter. A per-event pulse for each transmit or receive error or success updates these counters. From the counter values the block places the node in one of three states: error-active, error-passive or bus-off. It reports that state through two flags. It also keeps a three-bit code for the most recent error, and it raises an interrupt request when the state changes.

While the node is bus-off, the counters, the error code and the state stay fixed until recovery completes. Recovery counts runs of eleven consecutive recessive bits, sampled on a bit-time strobe; 128 such runs are needed. When the auto-recovery input is high, counting is armed on its own once the node is bus-off. When it is low, software must first raise the initialization-mode request and then drop it. While the request is high, the receive line is not watched, so the count does not move. When recovery completes, the node is error-active again with both counters at zero.

The controller sits beside the protocol engine. Bit timing, framing and CRC checking are done elsewhere, and they feed the event pulses into this block.

Top module: `can_fault_ctrl`

## Requirements
- R1: On each clock with `tx_err` high, `tec` rises by 8. Otherwise, a `tx_ok` pulse lowers `tec` by 1, and `tec` never goes below 0. The new value is visible on the cycle after the pulse.
- R2: On each clock with `rx_err` high, `rec` rises by 1 and holds at 255 once there. Otherwise, an `rx_ok` pulse lowers `rec` by 1, and `rec` never goes below 0.
- R3: `err_passive` is high when the node is not bus-off and either counter is 128 or more. It drops once both counters are 127 or less. It appears in the same cycle as the counter value that causes it.
- R4: When `tec` reaches 256 or more, `bus_off` goes high and `err_passive` goes low. While the node is bus-off, every error and success pulse is ignored: `tec`, `rec` and `lec` stay as they are.
- R5: While recovery is armed, a bus-off node leaves bus-off on the strobe that completes the 128th run of 11 consecutive recessive samples. A sample is taken when `bit_tick` is high, and `rx_bit` = 1 means recessive. A dominant sample restarts the current run but keeps the completed runs. On leaving bus-off, `bus_off` drops and `tec` and `rec` read 0.
- R6: With `auto_recover` = 1, recovery is armed within two cycles of entering bus-off, with no software action.
- R7: With `auto_recover` = 0, no amount of recessive bits ends bus-off until `init_req` has been high and then low while the node is bus-off.
- R8: Strobes that arrive while `init_req` is high do not count toward recovery.
- R9: `lec` resets to 0. On a cycle with `tx_err` or `rx_err` high while the node is not bus-off, `lec` takes the value of `err_code`.
- R10: When `irq_en` is high, `irq` is set on the cycle the state changes. The changes are: entering error-passive, leaving error-passive, entering bus-off and leaving bus-off. `irq` then stays high until an `irq_clr` pulse. A state change at the same time wins over the clear. A state change while `irq_en` is low leaves `irq` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_err | input | 1 | Transmit error detected (one-cycle pulse) |
| tx_ok | input | 1 | Successful transmission (one-cycle pulse) |
| rx_err | input | 1 | Receive error detected (one-cycle pulse) |
| rx_ok | input | 1 | Successful reception (one-cycle pulse) |
| err_code | input | 3 | Type of the error being reported with tx_err or rx_err |
| rx_bit | input | 1 | Sampled receive line, 1 = recessive |
| bit_tick | input | 1 | Bit-time strobe qualifying rx_bit |
| auto_recover | input | 1 | 1 = start bus-off recovery without software |
| init_req | input | 1 | Initialization-mode request from software |
| irq_en | input | 1 | Enables the state-change interrupt |
| irq_clr | input | 1 | Write-one pulse clearing irq |
| tec | output | 9 | Transmit error counter |
| rec | output | 8 | Receive error counter |
| bus_off | output | 1 | Node is bus-off |
| err_passive | output | 1 | Node is error-passive |
| lec | output | 3 | Code of the most recent error |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle:
- the step sizes of both counters and the receive counter's saturation;
- the freeze of counters and error code during bus-off;
- the consistency of the passive flag with the counters;
- that the completed-run count never falls, and that a dominant sample resets the current run;
- that strobes are ignored while initialization is requested;
- that the manual path stays unarmed;
- that the interrupt is set and held.

Only the bench scenarios can show the exact recovery length: bus-off must end on the 1408th counted recessive sample and not one earlier. They also show that recovery never completes with auto-recovery off until initialization mode has been entered and left. Finally, they show the full counter sweeps past the thresholds in both directions, with and without the interrupt enabled.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_PASSIVE = 2'd1,
    FC_BUSOFF  = 2'd2
  } fc_state_e;
endpackage

// File: rtl/can_fc_counters.sv
module can_fc_counters #(
  parameter int CNT_W   = 8,
  parameter int TX_STEP = 8,
  localparam int TEC_W  = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_err,
  input  logic             tx_ok,
  input  logic             rx_err,
  input  logic             rx_ok,
  input  logic             freeze,
  input  logic             clear,
  output logic [TEC_W-1:0] tec_q,
  output logic [CNT_W-1:0] rec_q,
  output logic [TEC_W-1:0] tec_nxt,
  output logic [CNT_W-1:0] rec_nxt
);
  logic upd;

  always_comb begin
    tec_nxt = tec_q;
    rec_nxt = rec_q;
    if (clear) begin
      tec_nxt = '0;
      rec_nxt = '0;
    end else if (!freeze) begin
      if (tx_err)
        tec_nxt = tec_q + TEC_W'(TX_STEP);
      else if (tx_ok && tec_q != '0)
        tec_nxt = tec_q - TEC_W'(1);
      if (rx_err) begin
        if (rec_q != '1) rec_nxt = rec_q + CNT_W'(1);
      end else if (rx_ok && rec_q != '0) begin
        rec_nxt = rec_q - CNT_W'(1);
      end
    end
  end

  assign upd = clear | (~freeze & (tx_err | tx_ok | rx_err | rx_ok));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tec_q <= '0;
      rec_q <= '0;
    end else if (upd) begin
      tec_q <= tec_nxt;
      rec_q <= rec_nxt;
    end
  end

  // R1
  tec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && !clear && tx_err) |=> tec_q == $past(tec_q) + TEC_W'(TX_STEP));
  // R2
  rec_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && !clear && rx_err && rec_q == '1) |=> rec_q == '1);
endmodule

// File: rtl/can_fc_recovery.sv
module can_fc_recovery #(
  parameter int RUN_LEN = 11,
  parameter int RUN_NUM = 128,
  localparam int BIT_W  = $clog2(RUN_LEN),
  localparam int RUN_W  = $clog2(RUN_NUM)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_busoff,
  input  logic auto_recover,
  input  logic init_req,
  input  logic bit_tick,
  input  logic rx_bit,
  output logic done
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(RUN_LEN - 1);
  localparam logic [RUN_W-1:0] LAST_RUN = RUN_W'(RUN_NUM - 1);

  logic             armed_q, armed_nxt;
  logic             saw_q, saw_nxt;
  logic [BIT_W-1:0] bit_q, bit_nxt;
  logic [RUN_W-1:0] run_q, run_nxt;
  logic             sample;

  assign sample = in_busoff & armed_q & ~init_req & bit_tick;

  always_comb begin
    armed_nxt = armed_q;
    saw_nxt   = saw_q;
    bit_nxt   = bit_q;
    run_nxt   = run_q;
    done      = 1'b0;
    if (!in_busoff) begin
      armed_nxt = 1'b0;
      saw_nxt   = 1'b0;
      bit_nxt   = '0;
      run_nxt   = '0;
    end else begin
      if (init_req) saw_nxt = 1'b1;
      if (auto_recover || (saw_q && !init_req)) armed_nxt = 1'b1;
      if (sample) begin
        if (!rx_bit) begin
          bit_nxt = '0;
        end else if (bit_q == LAST_BIT) begin
          bit_nxt = '0;
          if (run_q == LAST_RUN) done = 1'b1;
          else run_nxt = run_q + RUN_W'(1);
        end else begin
          bit_nxt = bit_q + BIT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      saw_q   <= 1'b0;
      bit_q   <= '0;
      run_q   <= '0;
    end else begin
      armed_q <= armed_nxt;
      saw_q   <= saw_nxt;
      bit_q   <= bit_nxt;
      run_q   <= run_nxt;
    end
  end

  // R5
  run_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_busoff && !done) |=> run_q >= $past(run_q));
  // R5
  dom_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !rx_bit) |=> bit_q == '0);
  // R8
  init_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_req |=> ($stable(bit_q) && $stable(run_q)));
  // R7
  manual_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_busoff && !armed_q && !saw_q && !auto_recover) |=> !armed_q);
endmodule

// File: rtl/can_fc_report.sv
module can_fc_report
  import can_fc_pkg::*;
#(
  parameter int LEC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze,
  input  logic             err_det,
  input  logic [LEC_W-1:0] err_code,
  input  fc_state_e        state_q,
  input  fc_state_e        state_nxt,
  input  logic             irq_en,
  input  logic             irq_clr,
  output logic [LEC_W-1:0] lec_q,
  output logic             irq_q
);
  logic lec_en;
  logic chg;
  logic irq_nxt;

  assign lec_en  = err_det & ~freeze;
  assign chg     = (state_nxt != state_q);
  assign irq_nxt = (chg & irq_en) | (irq_q & ~irq_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lec_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (lec_en) lec_q <= err_code;
      irq_q <= irq_nxt;
    end
  end

  // R9
  lec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lec_en |=> lec_q == $past(err_code));
  // R10
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg && irq_en) |=> irq_q);
  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_clr) |=> irq_q);
endmodule

// File: rtl/can_fault_ctrl.sv
module can_fault_ctrl
  import can_fc_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int TX_STEP = 8,
  parameter int RUN_LEN = 11,
  parameter int RUN_NUM = 128,
  parameter int LEC_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_err,
  input  logic             tx_ok,
  input  logic             rx_err,
  input  logic             rx_ok,
  input  logic [LEC_W-1:0] err_code,
  input  logic             rx_bit,
  input  logic             bit_tick,
  input  logic             auto_recover,
  input  logic             init_req,
  input  logic             irq_en,
  input  logic             irq_clr,
  output logic [CNT_W:0]   tec,
  output logic [CNT_W-1:0] rec,
  output logic             bus_off,
  output logic             err_passive,
  output logic [LEC_W-1:0] lec,
  output logic             irq
);
  localparam int TEC_W       = CNT_W + 1;
  localparam int LIM_PASSIVE = 1 << (CNT_W - 1);
  localparam int LIM_BUSOFF  = 1 << CNT_W;

  logic [1:0]       rst_sync;
  logic             rst_s;
  fc_state_e        state_q, state_nxt;
  logic [TEC_W-1:0] tec_nxt;
  logic [CNT_W-1:0] rec_nxt;
  logic             in_busoff;
  logic             recov_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  assign in_busoff = (state_q == FC_BUSOFF);

  can_fc_counters #(.CNT_W(CNT_W), .TX_STEP(TX_STEP)) u_cnt (
    .clk(clk), .rst_n(rst_s),
    .tx_err(tx_err), .tx_ok(tx_ok), .rx_err(rx_err), .rx_ok(rx_ok),
    .freeze(in_busoff), .clear(recov_done),
    .tec_q(tec), .rec_q(rec), .tec_nxt(tec_nxt), .rec_nxt(rec_nxt)
  );

  can_fc_recovery #(.RUN_LEN(RUN_LEN), .RUN_NUM(RUN_NUM)) u_rcv (
    .clk(clk), .rst_n(rst_s), .in_busoff(in_busoff),
    .auto_recover(auto_recover), .init_req(init_req),
    .bit_tick(bit_tick), .rx_bit(rx_bit), .done(recov_done)
  );

  always_comb begin
    state_nxt = state_q;
    if (in_busoff) begin
      if (recov_done) state_nxt = FC_ACTIVE;
    end else if (tec_nxt >= TEC_W'(LIM_BUSOFF)) begin
      state_nxt = FC_BUSOFF;
    end else if (tec_nxt >= TEC_W'(LIM_PASSIVE) || rec_nxt >= CNT_W'(LIM_PASSIVE)) begin
      state_nxt = FC_PASSIVE;
    end else begin
      state_nxt = FC_ACTIVE;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) state_q <= FC_ACTIVE;
    else        state_q <= state_nxt;
  end

  can_fc_report #(.LEC_W(LEC_W)) u_rep (
    .clk(clk), .rst_n(rst_s), .freeze(in_busoff),
    .err_det(tx_err | rx_err), .err_code(err_code),
    .state_q(state_q), .state_nxt(state_nxt),
    .irq_en(irq_en), .irq_clr(irq_clr),
    .lec_q(lec), .irq_q(irq)
  );

  assign bus_off     = in_busoff;
  assign err_passive = (state_q == FC_PASSIVE);

  // R4
  busoff_freeze_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_off && !recov_done) |=> ($stable(tec) && $stable(rec) && $stable(lec)));
  // R3
  passive_flag_chk: assert property (@(posedge clk) disable iff (!rst_s)
    err_passive |-> ((tec >= TEC_W'(LIM_PASSIVE) || rec >= CNT_W'(LIM_PASSIVE)) && !bus_off));
  // R5
  recov_clear_chk: assert property (@(posedge clk) disable iff (!rst_s)
    recov_done |=> (!bus_off && tec == '0 && rec == '0));
endmodule

// File: tb/can_fault_ctrl_test.sv
module can_fault_ctrl_test;
  logic clk, rst_n;
  logic tx_err, tx_ok, rx_err, rx_ok;
  logic [2:0] err_code;
  logic rx_bit, bit_tick, auto_recover, init_req, irq_en, irq_clr;
  logic [8:0] tec;
  logic [7:0] rec;
  logic bus_off, err_passive, irq;
  logic [2:0] lec;

  int checks = 0, errors = 0;
  int e_tec = 0, e_rec = 0, e_lec = 0;
  bit e_bo = 0, e_irq = 0, e_rcv = 0, finished = 0;
  string bo_tag = "R4";

  can_fault_ctrl uut (
    .clk(clk), .rst_n(rst_n), .tx_err(tx_err), .tx_ok(tx_ok),
    .rx_err(rx_err), .rx_ok(rx_ok), .err_code(err_code),
    .rx_bit(rx_bit), .bit_tick(bit_tick), .auto_recover(auto_recover),
    .init_req(init_req), .irq_en(irq_en), .irq_clr(irq_clr),
    .tec(tec), .rec(rec), .bus_off(bus_off), .err_passive(err_passive),
    .lec(lec), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int st_of();
    if (e_bo) return 2;
    if (e_tec > 127 || e_rec > 127) return 1;
    return 0;
  endfunction

  task automatic check_all();
    chk("R1", "tec", int'(tec), e_tec);
    chk("R2", "rec", int'(rec), e_rec);
    chk("R3", "err_passive", int'(err_passive), int'(st_of() == 1));
    chk(bo_tag, "bus_off", int'(bus_off), int'(e_bo));
    chk("R9", "lec", int'(lec), e_lec);
    chk("R10", "irq", int'(irq), int'(e_irq));
  endtask

  task automatic step();
    int ps, ns;
    ps = st_of();
    if (e_bo) begin
      if (e_rcv) begin e_bo = 0; e_tec = 0; e_rec = 0; end
    end else begin
      if (tx_err) e_tec += 8;
      else if (tx_ok && e_tec > 0) e_tec--;
      if (rx_err) begin if (e_rec < 255) e_rec++; end
      else if (rx_ok && e_rec > 0) e_rec--;
      if (tx_err || rx_err) e_lec = int'(err_code);
      if (e_tec > 255) e_bo = 1;
    end
    ns = st_of();
    if (ns != ps && irq_en) e_irq = 1;
    else if (irq_clr) e_irq = 0;
    @(posedge clk); #1;
    tx_err = 0; tx_ok = 0; rx_err = 0; rx_ok = 0; irq_clr = 0;
    bit_tick = 0; rx_bit = 1; e_rcv = 0;
    check_all();
  endtask

  task automatic tick(bit v, bit completes);
    bit_tick = 1; rx_bit = v; e_rcv = completes;
    step();
  endtask

  task automatic clr_irq();
    irq_clr = 1; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tx_err = 0; tx_ok = 0; rx_err = 0; rx_ok = 0; err_code = 0;
    rx_bit = 1; bit_tick = 0; auto_recover = 0; init_req = 0;
    irq_en = 1; irq_clr = 0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    repeat (4) @(posedge clk); #1;
    check_all();   // reset state, R9 lec = 0

    // R2 / R3 / R10: receive counter sweep up through saturation and back
    for (int i = 0; i < 260; i++) begin
      rx_err = 1; err_code = 3'(i % 8); step();
    end
    clr_irq();
    for (int i = 0; i < 260; i++) begin
      rx_ok = 1; step();
    end
    clr_irq();

    // R10: state changes with the enable low leave irq low
    irq_en = 0;
    for (int i = 0; i < 130; i++) begin rx_err = 1; err_code = 3'd6; step(); end
    for (int i = 0; i < 130; i++) begin rx_ok = 1; step(); end
    irq_en = 1;

    // R1: floor at zero, error wins over success, mixed traffic to bus-off
    tx_ok = 1; step();
    tx_err = 1; tx_ok = 1; err_code = 3'd2; step();
    tx_ok = 1; step();
    for (int i = 0; i < 60; i++) begin
      if (!e_bo) begin
        tx_err = 1; rx_err = (i % 3 == 0); rx_ok = (i % 3 == 1);
        err_code = 3'((i * 5) % 8); step();
        if (i % 4 == 0 && !e_bo) begin tx_ok = 1; step(); end
      end
    end
    chk("R4", "entered bus-off", int'(bus_off), 1);

    // R4: events in bus-off are ignored
    tx_err = 1; rx_err = 1; err_code = 3'd7; step();
    tx_ok = 1; rx_ok = 1; step();
    clr_irq();

    // R7: manual mode, recessive traffic does nothing before init cycle
    bo_tag = "R7";
    for (int i = 0; i < 1500; i++) tick(1, 0);
    init_req = 1; step();
    init_req = 0; step(); step();
    // R8: strobes during init request are not counted
    bo_tag = "R8";
    init_req = 1;
    for (int i = 0; i < 40; i++) tick(1, 0);
    init_req = 0; step();
    // R5: exact count with a dominant bit restarting a run
    bo_tag = "R5";
    for (int i = 0; i < 127 * 11; i++) tick(1, 0);
    for (int i = 0; i < 5; i++) tick(1, 0);
    tick(0, 0);
    for (int i = 0; i < 10; i++) tick(1, 0);
    tick(1, 1);
    chk("R5", "tec cleared", int'(tec), 0);
    clr_irq();

    // R6: automatic recovery after a second bus-off entry
    bo_tag = "R6";
    auto_recover = 1;
    for (int i = 0; i < 40; i++) begin
      if (!e_bo) begin tx_err = 1; err_code = 3'd4; step(); end
    end
    step(); step();
    for (int i = 0; i < 128 * 11 - 1; i++) tick(1, 0);
    tick(1, 1);
    chk("R6", "recovered", int'(bus_off), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule